// File: doc/BRIEF.md
# Single-Line Hub Read Cache

This block sits between one processor core and a shared hub memory whose port is handed to each core in turn by a rotating time slot. The core presents one access at a time and holds it until the block signals completion. An access is a byte, word or long read, either cached or uncached, or a write of one of those sizes. The block turns each access into at most one hub operation, issued only in this core's slot.

The block keeps one 16-byte line made of four 32-bit longs. A cached read that falls inside the held line is answered straight from the line, with no wait for the slot. A cached read outside it costs exactly what an uncached read costs. The hub returns the whole line in one transfer, so the same read also refills the line. A write to an address inside the held line drops the line. Uncached reads leave the line alone. The slot rotation and the hub memory are outside the block.

Top module: `hub_line_cache`

## Requirements
- R1: The line is 16 bytes, and address bits [3:0] select the byte inside it. One fill stores all four longs, so a cached read of any byte of that line afterwards returns the memory contents.
- R2: A cached read whose address is inside the valid line asserts `req_done` in the cycle it is first presented, whatever the slot position, and issues no hub operation.
- R3: A cached read that misses has uncached-read timing, and its completion leaves the line valid and holding the line of that address.
- R4: An uncached read issues `hub_rd_en` in the first cycle at or after presentation in which `slot_mine` is high. `req_done` follows one cycle later, so the read takes two clocks when presented in the slot.
- R5: A write completes in the first cycle at or after presentation in which `slot_mine` is high, so it takes one clock when presented in the slot. `hub_be` marks bytes 0..3 of the long, bit n for byte n. It is `0001<<addr[1:0]` for a byte, `0011` or `1100` by addr[1] for a word, and `1111` for a long. The data is replicated across the lanes.
- R6: `req_size` encodes 0 byte, 1 word, 2 or 3 long. The read data is zero-extended: byte lane addr[1:0], halfword addr[1], or the whole long.
- R7: Reset clears the valid bit, so the first cached read after any reset misses.
- R8: A write inside the valid line clears the valid bit. A write outside it leaves the line valid.
- R9: Uncached reads never fill, change or drop the line.
- R10: Sixteen cached byte reads at consecutive addresses of one line that is not held give one access with uncached timing (the first) and fifteen one-clock accesses.
- R11: At most one of `hub_rd_en` and `hub_wr_en` is high in any cycle, and either is high only while `slot_mine` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access presented, held until done |
| req_write | input | 1 | 1 write, 0 read |
| req_cached | input | 1 | Read may use and fill the line |
| req_size | input | 2 | 0 byte, 1 word, 2/3 long |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data, right-aligned |
| req_done | output | 1 | Access completes this cycle |
| req_rdata | output | 32 | Read result, valid with req_done |
| slot_mine | input | 1 | Hub slot belongs to this core this cycle |
| hub_rd_en | output | 1 | Line read request to hub |
| hub_wr_en | output | 1 | Long write request to hub |
| hub_addr | output | ADDR_W-2 | Long address |
| hub_be | output | 4 | Byte enables for writes |
| hub_wdata | output | 32 | Lane-replicated write data |
| hub_rdata | input | 128 | Line returned the cycle after hub_rd_en |

## Verification
The assertions rely on three things from outside the block:
- the core holds every field of a request steady from presentation until `req_done`;
- the hub answers a line read in the very next cycle;
- `slot_mine` comes from a rotation that never grants two adjacent cycles.

The bench follows these rules. Every access is driven by one task that holds the request until completion and drops it after the commit edge. The hub model registers its read data. The slot comes from an eight-step counter.

// File: rtl/hub_cache_pkg.sv
package hub_cache_pkg;

    localparam int LONG_W  = 32;
    localparam int LANES   = LONG_W / 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_LONG_ALT = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic      write;
        logic      cached;
        acc_size_e size;
    } acc_kind_t;

    // Byte enables within one long for an access of a given size.
    function automatic logic [LANES-1:0] lane_mask(acc_size_e sz, logic [1:0] off);
        logic [LANES-1:0] m;
        case (sz)
            SZ_BYTE: m = 4'b0001 << off;
            SZ_WORD: m = off[1] ? 4'b1100 : 4'b0011;
            default: m = 4'b1111;
        endcase
        return m;
    endfunction

    // Replicate right-aligned write data across every lane it could occupy.
    function automatic logic [LONG_W-1:0] lane_spread(acc_size_e sz, logic [LONG_W-1:0] d);
        logic [LONG_W-1:0] r;
        case (sz)
            SZ_BYTE: r = {4{d[7:0]}};
            SZ_WORD: r = {2{d[15:0]}};
            default: r = d;
        endcase
        return r;
    endfunction

    // Zero-extended extraction of a byte, word or long from one long.
    function automatic logic [LONG_W-1:0] lane_pick(acc_size_e sz, logic [LONG_W-1:0] l,
                                                    logic [1:0] off);
        logic [LONG_W-1:0] r;
        case (sz)
            SZ_BYTE: r = {24'h0, l[{off, 3'b000} +: 8]};
            SZ_WORD: r = off[1] ? {16'h0, l[31:16]} : {16'h0, l[15:0]};
            default: r = l;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/hub_cache_line_store.sv
module hub_cache_line_store
    import hub_cache_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int LINE_LONGS = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [ADDR_W-OFF_W-1:0]      lookup_tag,
    input  logic                         fill_en,
    input  logic [LINE_LONGS*LONG_W-1:0] fill_data,
    input  logic                         inval_en,
    output logic                         tag_hit,
    output logic                         line_valid,
    output logic [LINE_LONGS*LONG_W-1:0] line_data
);
    localparam int OFF_W = $clog2(LINE_LONGS * LANES);
    localparam int TAG_W = ADDR_W - OFF_W;

    logic             valid_q;
    logic [TAG_W-1:0] tag_q;
    logic [LONG_W-1:0] longs_q [LINE_LONGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            tag_q   <= '0;
        end else if (fill_en) begin
            valid_q <= 1'b1;
            tag_q   <= lookup_tag;
        end else if (inval_en) begin
            valid_q <= 1'b0;
        end
    end

    for (genvar gi = 0; gi < LINE_LONGS; gi++) begin : g_long
        always_ff @(posedge clk) begin
            if (fill_en) longs_q[gi] <= fill_data[gi*LONG_W +: LONG_W];
        end
        assign line_data[gi*LONG_W +: LONG_W] = longs_q[gi];
    end

    assign tag_hit    = valid_q && (tag_q == lookup_tag);
    assign line_valid = valid_q;

    // R3: a fill leaves the line valid on the next cycle
    a_r3_fill_sets_valid: assert property (@(posedge clk) disable iff (rst)
        fill_en |=> line_valid);
    // R8: invalidation drops the line on the next cycle
    a_r8_inval_clears: assert property (@(posedge clk) disable iff (rst)
        (inval_en && !fill_en) |=> !line_valid);
endmodule

// File: rtl/hub_cache_slot_seq.sv
module hub_cache_slot_seq (
    input  logic clk,
    input  logic rst,
    input  logic need_hub,
    input  logic is_write,
    input  logic slot_mine,
    output logic hub_rd_en,
    output logic hub_wr_en,
    output logic rd_pend,
    output logic seq_done
);
    logic pend_q;

    assign hub_rd_en = need_hub && !is_write && slot_mine && !pend_q;
    assign hub_wr_en = need_hub && is_write && slot_mine;
    assign seq_done  = pend_q || hub_wr_en;
    assign rd_pend   = pend_q;

    always_ff @(posedge clk) begin
        if (rst) pend_q <= 1'b0;
        else     pend_q <= hub_rd_en;
    end

    // R4: a pending read lasts exactly one cycle
    a_r4_pend_single: assert property (@(posedge clk) disable iff (rst)
        rd_pend |=> !rd_pend);
    // R11: reads and writes never overlap
    a_r11_one_op: assert property (@(posedge clk) disable iff (rst)
        $onehot0({hub_rd_en, hub_wr_en}));
endmodule

// File: rtl/hub_cache_read_align.sv
module hub_cache_read_align
    import hub_cache_pkg::*;
#(
    parameter int LINE_LONGS = 4
) (
    input  logic [LINE_LONGS*LONG_W-1:0] line,
    input  logic [OFF_W-1:0]             offset,
    input  acc_size_e                    size,
    output logic [LONG_W-1:0]            data
);
    localparam int OFF_W = $clog2(LINE_LONGS * LANES);
    localparam int SEL_W = OFF_W - 2;

    logic [SEL_W-1:0]  sel;
    logic [LONG_W-1:0] picked;

    assign sel = offset[OFF_W-1:2];

    always_comb begin
        picked = '0;
        for (int i = 0; i < LINE_LONGS; i++) begin
            if (sel == i[SEL_W-1:0]) picked = line[i*LONG_W +: LONG_W];
        end
    end

    assign data = lane_pick(size, picked, offset[1:0]);
endmodule

// File: rtl/hub_line_cache.sv
module hub_line_cache
    import hub_cache_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int LINE_LONGS = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         req_valid,
    input  logic                         req_write,
    input  logic                         req_cached,
    input  logic [1:0]                   req_size,
    input  logic [ADDR_W-1:0]            req_addr,
    input  logic [31:0]                  req_wdata,
    output logic                         req_done,
    output logic [31:0]                  req_rdata,
    input  logic                         slot_mine,
    output logic                         hub_rd_en,
    output logic                         hub_wr_en,
    output logic [ADDR_W-3:0]            hub_addr,
    output logic [3:0]                   hub_be,
    output logic [31:0]                  hub_wdata,
    input  logic [LINE_LONGS*LONG_W-1:0] hub_rdata
);
    localparam int OFF_W  = $clog2(LINE_LONGS * LANES);
    localparam int TAG_W  = ADDR_W - OFF_W;
    localparam int LINE_W = LINE_LONGS * LONG_W;

    acc_kind_t         kind;
    logic [TAG_W-1:0]  tag;
    logic              tag_hit, line_valid, rd_pend, seq_done;
    logic              rd_req, cached_rd, use_line, need_hub;
    logic              fill_en, inval_en;
    logic [LINE_W-1:0] line_data, src_line;
    logic [LONG_W-1:0] aligned;

    assign kind      = '{write: req_write, cached: req_cached, size: acc_size_e'(req_size)};
    assign tag       = req_addr[ADDR_W-1:OFF_W];
    assign rd_req    = req_valid && !kind.write;
    assign cached_rd = rd_req && kind.cached;
    assign use_line  = cached_rd && tag_hit && !rd_pend;
    assign need_hub  = req_valid && !use_line;
    assign fill_en   = rd_pend && cached_rd;
    assign inval_en  = hub_wr_en && tag_hit;

    hub_cache_line_store #(.ADDR_W(ADDR_W), .LINE_LONGS(LINE_LONGS)) u_store (
        .clk        (clk),
        .rst        (rst),
        .lookup_tag (tag),
        .fill_en    (fill_en),
        .fill_data  (hub_rdata),
        .inval_en   (inval_en),
        .tag_hit    (tag_hit),
        .line_valid (line_valid),
        .line_data  (line_data)
    );

    hub_cache_slot_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .need_hub  (need_hub),
        .is_write  (kind.write),
        .slot_mine (slot_mine),
        .hub_rd_en (hub_rd_en),
        .hub_wr_en (hub_wr_en),
        .rd_pend   (rd_pend),
        .seq_done  (seq_done)
    );

    assign src_line = rd_pend ? hub_rdata : line_data;

    hub_cache_read_align #(.LINE_LONGS(LINE_LONGS)) u_align (
        .line   (src_line),
        .offset (req_addr[OFF_W-1:0]),
        .size   (kind.size),
        .data   (aligned)
    );

    assign req_done  = use_line || seq_done;
    assign req_rdata = (req_done && rd_req) ? aligned : '0;
    assign hub_addr  = req_addr[ADDR_W-1:2];
    assign hub_be    = lane_mask(kind.size, req_addr[1:0]);
    assign hub_wdata = lane_spread(kind.size, req_wdata);

    // R2: a line hit never goes to the hub
    a_r2_hit_no_hub: assert property (@(posedge clk) disable iff (rst)
        (cached_rd && tag_hit) |-> !hub_rd_en);
    // R4: read data arrives exactly one cycle after the hub read
    a_r4_done_after_issue: assert property (@(posedge clk) disable iff (rst)
        hub_rd_en |=> (req_done && !hub_rd_en));
    // R5: a hub write completes the access in that cycle
    a_r5_write_done: assert property (@(posedge clk) disable iff (rst)
        hub_wr_en |-> req_done);
    // R11: hub operations only in this core's slot
    a_r11_slot_only: assert property (@(posedge clk) disable iff (rst)
        (hub_rd_en || hub_wr_en) |-> slot_mine);
    // R3: a finished cached read leaves the line valid
    a_r3_valid_after_cached: assert property (@(posedge clk) disable iff (rst)
        (req_done && cached_rd) |=> line_valid);
    // R9: an uncached read leaves the valid bit untouched
    a_r9_uncached_keeps: assert property (@(posedge clk) disable iff (rst)
        (req_done && rd_req && !kind.cached) |=> $stable(line_valid));
endmodule

// File: tb/hub_line_cache_bench.sv
`timescale 1ns/1ps
module hub_line_cache_bench;
    localparam int ADDR_W  = 20;
    localparam int MY_SLOT = 5;
    localparam int NVEC    = 16;

    // {exp_hit, write, cached, size[1:0], addr[11:0], wdata[31:0]}
    localparam logic [48:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 1'b1, 2'd2, 12'h040, 32'h0},
        {1'b1, 1'b0, 1'b1, 2'd0, 12'h043, 32'h0},
        {1'b1, 1'b0, 1'b1, 2'd1, 12'h04E, 32'h0},
        {1'b0, 1'b0, 1'b0, 2'd2, 12'h100, 32'h0},
        {1'b1, 1'b0, 1'b1, 2'd0, 12'h045, 32'h0},
        {1'b0, 1'b1, 1'b0, 2'd0, 12'h200, 32'h0000005A},
        {1'b1, 1'b0, 1'b1, 2'd2, 12'h048, 32'h0},
        {1'b0, 1'b1, 1'b0, 2'd1, 12'h046, 32'h0000BEEF},
        {1'b0, 1'b0, 1'b1, 2'd0, 12'h046, 32'h0},
        {1'b1, 1'b0, 1'b1, 2'd2, 12'h04C, 32'h0},
        {1'b0, 1'b0, 1'b0, 2'd0, 12'h047, 32'h0},
        {1'b0, 1'b1, 1'b0, 2'd3, 12'h080, 32'hCAFEF00D},
        {1'b0, 1'b0, 1'b1, 2'd2, 12'h080, 32'h0},
        {1'b0, 1'b0, 1'b1, 2'd2, 12'h044, 32'h0},
        {1'b0, 1'b0, 1'b0, 2'd2, 12'h300, 32'h0},
        {1'b0, 1'b0, 1'b1, 2'd2, 12'h300, 32'h0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0, req_cached = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic req_done;
    logic [31:0] req_rdata;
    logic slot_mine;
    logic hub_rd_en, hub_wr_en;
    logic [ADDR_W-3:0] hub_addr;
    logic [3:0] hub_be;
    logic [31:0] hub_wdata;
    logic [127:0] hub_rdata;

    logic [2:0] slot_cnt;
    logic mem_init = 1'b1;
    logic [31:0] mem [1024];
    logic [31:0] ref_mem [1024];
    int errs = 0, checks = 0, bad_hub = 0;

    always #10 clk = ~clk;

    hub_line_cache #(.ADDR_W(ADDR_W)) u_hub_line_cache (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_cached(req_cached), .req_size(req_size), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_done(req_done), .req_rdata(req_rdata),
        .slot_mine(slot_mine), .hub_rd_en(hub_rd_en), .hub_wr_en(hub_wr_en),
        .hub_addr(hub_addr), .hub_be(hub_be), .hub_wdata(hub_wdata),
        .hub_rdata(hub_rdata)
    );

    function automatic logic [31:0] init_long(int i);
        return 32'h89AB_CDEF + i * 32'h0103_0507;
    endfunction

    always @(posedge clk) begin
        if (rst) slot_cnt <= 3'd0;
        else     slot_cnt <= slot_cnt + 3'd1;
    end
    assign slot_mine = (slot_cnt == 3'(MY_SLOT));

    // hub memory model: line read answered the next cycle
    always @(posedge clk) begin
        if (mem_init) begin
            for (int i = 0; i < 1024; i++) mem[i] <= init_long(i);
        end else begin
            if (hub_rd_en)
                hub_rdata <= {mem[{hub_addr[9:2], 2'd3}], mem[{hub_addr[9:2], 2'd2}],
                              mem[{hub_addr[9:2], 2'd1}], mem[{hub_addr[9:2], 2'd0}]};
            if (hub_wr_en)
                for (int b = 0; b < 4; b++)
                    if (hub_be[b]) mem[hub_addr[9:0]][b*8 +: 8] <= hub_wdata[b*8 +: 8];
        end
    end

    // R11 monitor
    always @(negedge clk) begin
        if (!rst && ((hub_rd_en && hub_wr_en) || ((hub_rd_en || hub_wr_en) && !slot_mine)))
            bad_hub <= bad_hub + 1;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(logic [1:0] sz, logic [11:0] a);
        logic [31:0] l = ref_mem[a[11:2]];
        case (sz)
            2'd0: return {24'h0, l[a[1:0]*8 +: 8]};
            2'd1: return a[1] ? {16'h0, l[31:16]} : {16'h0, l[15:0]};
            default: return l;
        endcase
    endfunction

    function automatic logic [3:0] exp_be(logic [1:0] sz, logic [1:0] off);
        case (sz)
            2'd0: return 4'(1 << off);
            2'd1: return off[1] ? 4'b1100 : 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    // One access: presented at a negedge, held until done, dropped after the commit edge.
    task automatic access(input bit w, input bit c, input logic [1:0] sz,
                          input logic [11:0] a, input logic [31:0] wd,
                          output int cyc, output int k, output logic [31:0] rd);
        logic [3:0] be_seen;
        bit wr_seen;
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_cached = c; req_size = sz;
        req_addr = ADDR_W'(a); req_wdata = wd;
        #1;
        k = (MY_SLOT + 8 - int'(slot_cnt)) % 8;
        cyc = 1;
        while (!req_done && cyc < 100) begin
            @(negedge clk); #1; cyc++;
        end
        rd = req_rdata; be_seen = hub_be; wr_seen = hub_wr_en;
        @(posedge clk); #1;
        req_valid = 1'b0;
        if (w) begin
            logic [3:0] m = exp_be(sz, a[1:0]);
            logic [31:0] d = (sz == 2'd0) ? {4{wd[7:0]}} : (sz == 2'd1) ? {2{wd[15:0]}} : wd;
            check(wr_seen && be_seen == m, "R5 byte enables", {27'h0, wr_seen, be_seen},
                  {28'h1, m});
            for (int b = 0; b < 4; b++)
                if (m[b]) ref_mem[a[11:2]][b*8 +: 8] = d[b*8 +: 8];
            check(mem[a[11:2]] == ref_mem[a[11:2]], "R5 hub long after write",
                  mem[a[11:2]], ref_mem[a[11:2]]);
        end
    endtask

    task automatic wait_pre_slot();
        @(negedge clk);
        while (slot_cnt != 3'((MY_SLOT + 7) % 8)) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    task automatic run_all();
        int cyc, k, slow;
        logic [31:0] rd;
        for (int i = 0; i < 1024; i++) ref_mem[i] = init_long(i);
        @(negedge clk); @(negedge clk);
        mem_init = 1'b0;
        // R7 reset state
        @(negedge clk); #1;
        check(!req_done && !hub_rd_en && !hub_wr_en, "R7 outputs in reset",
              {29'h0, req_done, hub_rd_en, hub_wr_en}, 32'h0);
        rst = 1'b0;

        // vector table
        for (int i = 0; i < NVEC; i++) begin
            logic [48:0] v = VEC[i];
            int ecyc;
            string tg;
            access(v[47], v[46], v[45:44], v[43:32], v[31:0], cyc, k, rd);
            if (v[47]) begin ecyc = k + 1; tg = "R5 write cycles"; end
            else if (v[48]) begin ecyc = 1; tg = "R2 hit cycles"; end
            else if (v[46]) begin ecyc = k + 2; tg = "R3 miss cycles"; end
            else begin ecyc = k + 2; tg = "R4 uncached cycles"; end
            if (i == 4 || i == 6 || i == 9) tg = {tg, " R9/R8 line kept"};
            if (i == 8 || i == 15) tg = {tg, " R8/R9 line dropped or not filled"};
            check(cyc == ecyc, tg, 32'(cyc), 32'(ecyc));
            if (!v[47])
                check(rd == exp_read(v[45:44], v[43:32]), "R6 read data", rd,
                      exp_read(v[45:44], v[43:32]));
        end

        // R10 sequential byte run, R1 all bytes of one fill
        slow = 0;
        for (int j = 0; j < 16; j++) begin
            access(1'b0, 1'b1, 2'd0, 12'h0C0 + 12'(j), 32'h0, cyc, k, rd);
            if (cyc != 1) begin
                slow++;
                check(j == 0 && cyc == k + 2, "R10 slow access position/timing",
                      32'(cyc), 32'(k + 2));
            end
            check(rd == exp_read(2'd0, 12'h0C0 + 12'(j)), "R1 byte from filled line", rd,
                  exp_read(2'd0, 12'h0C0 + 12'(j)));
        end
        check(slow == 1, "R10 one slow access per line", 32'(slow), 32'd1);

        // R4 and R5 exactly on the slot
        wait_pre_slot();
        access(1'b0, 1'b0, 2'd2, 12'h104, 32'h0, cyc, k, rd);
        check(k == 0 && cyc == 2, "R4 uncached read on slot takes 2", 32'(cyc), 32'd2);
        wait_pre_slot();
        access(1'b1, 1'b0, 2'd0, 12'h20B, 32'h000000C3, cyc, k, rd);
        check(k == 0 && cyc == 1, "R5 write on slot takes 1", 32'(cyc), 32'd1);

        // R2 hit independent of slot: try hit at several slot phases
        access(1'b0, 1'b1, 2'd2, 12'h0C4, 32'h0, cyc, k, rd);
        for (int p = 0; p < 3; p++) begin
            access(1'b0, 1'b1, 2'd1, 12'h0CA, 32'h0, cyc, k, rd);
            check(cyc == 1, "R2 hit at any slot phase", 32'(cyc), 32'd1);
        end

        // R7 mid-run reset drops the line
        do_reset();
        access(1'b0, 1'b1, 2'd2, 12'h0C8, 32'h0, cyc, k, rd);
        check(cyc == k + 2, "R7 cached read after reset misses", 32'(cyc), 32'(k + 2));
        check(rd == exp_read(2'd2, 12'h0C8), "R7 data after reset", rd,
              exp_read(2'd2, 12'h0C8));

        check(bad_hub == 0, "R11 hub ops only in slot, one at a time", 32'(bad_hub), 32'd0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                checks++; errs++;
                $display("FAIL watchdog: actual=timeout expected=finish");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule